// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This peripheral holds two or three independent 32-bit timer channels behind a single-cycle register port. Each channel divides the common clock through its own selectable prescaler. On every prescaled tick it counts down by one. When a tick finds the counter at zero, the channel reloads the counter from its constant register and raises a sticky underflow flag. A constant of N therefore gives one event every N+1 ticks.

A single shared start register holds one run bit per channel. Software sets or clears the bit for one channel with a read-modify-write and leaves the other bits unchanged. Each channel drives a level-sensitive interrupt line. The line is high while the channel's underflow flag and its interrupt enable are both set. Software acknowledges the interrupt by writing the channel's control register with the flag bit at zero.

Top module: `tmr_unit`

## Requirements
- R1: The parameter `NCH` sets the channel count, and only 2 or 3 is accepted. A read of the register addresses that a further channel would occupy (for example byte address 44 when `NCH` is 3) returns zero.
- R2: The start register sits at byte address 4, or at address 2 when `LEGACY` is 1. A write loads `bus_wdata[NCH-1:0]` into it whatever `bus_wstrb` holds. Bit n set to 1 runs channel n. Bits at `NCH` and above read as zero.
- R3: Channel n places its registers at base 8+12n (base 4+12n when `LEGACY` is 1). The constant register is at base+0, the counter at base+4 and the control register at base+8. All three are 32 bits wide, and a write changes only the bytes whose `bus_wstrb` bit is set.
- R4: Control bits 2:0 pick the prescaler. Codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clocks of run time, and codes 5 to 7 give no ticks. The first tick comes at the end of the divide-th cycle in which the channel runs.
- R5: On each tick the counter decrements by one when it is not zero.
- R6: A tick that finds the counter at zero loads the counter from the constant register and sets the underflow flag (control bit 8) at the same clock edge.
- R7: A control write that has `bus_wstrb[1]` set and bit 8 at zero clears the flag. Writing 1 to bit 8 has no effect. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: `irq[n]` equals flag AND interrupt enable (control bit 5) of channel n, as a level.
- R9: A stopped channel holds its counter, and its prescaler restarts from zero when the channel runs again.
- R10: A counter write in the same cycle as a tick takes the written value and produces no underflow.
- R11: Reserved control bits, unmapped addresses, and `bus_rdata` while `bus_rd` is low all read as zero.
- R12: After reset the start register and the control registers are zero, and the constant and counter registers are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write enables |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | NCH | Level interrupt per channel |

## Verification
The assertions assume that the strobes, address and data are known and stay steady through each clock cycle. They also assume that each cycle carries at most one access. The bench drives every bus input on the falling edge and issues writes as single-cycle pulses. Some writes are issued while the counters are underflowing, with their phase stepped by one idle cycle, so that clearing writes and counter writes land both on and off tick cycles. A behavioural model advances at every rising edge, and the bench compares the interrupt lines and every read against it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int PS_W     = 10;
    localparam int SEL_W    = 3;
    localparam int BIT_FLAG = 8;
    localparam int BIT_IE   = 5;

    typedef struct packed {
        logic             flag;
        logic             ie;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    function automatic logic sel_ok(input logic [SEL_W-1:0] s);
        return s <= SEL_W'(4);
    endfunction

    // last prescaler count before a tick (divide ratio minus one)
    function automatic logic [PS_W-1:0] ps_last(input logic [SEL_W-1:0] s);
        case (s)
            3'd0:    return PS_W'(3);
            3'd1:    return PS_W'(15);
            3'd2:    return PS_W'(63);
            3'd3:    return PS_W'(255);
            3'd4:    return PS_W'(1023);
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] cur,
                                                      input logic [DATA_W-1:0] nw,
                                                      input logic [DATA_W/8-1:0] strb);
        logic [DATA_W-1:0] r;
        r = cur;
        for (int k = 0; k < DATA_W/8; k++)
            if (strb[k]) r[8*k +: 8] = nw[8*k +: 8];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_FLAG]    = c.flag;
        w[BIT_IE]      = c.ie;
        w[SEL_W-1:0]   = c.sel;
        return w;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PS_W-1:0] ps_q;
    logic            active;

    assign active = run && sel_ok(sel);
    // >= keeps a prescaler change while running from stalling
    assign tick   = active && (ps_q >= ps_last(sel));

    always_ff @(posedge clk) begin
        if (rst || !active || tick) ps_q <= '0;
        else                        ps_q <= ps_q + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R4
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick); // R9
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                wr_const,
    input  logic                wr_count,
    input  logic                wr_ctrl,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic [DATA_W-1:0]   const_q,
    output logic [DATA_W-1:0]   count_q,
    output ctrl_t               ctrl_q,
    output logic                irq
);
    logic tick;
    logic underflow;
    logic flag_clr;

    tmr_prescaler u_ps (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sel  (ctrl_q.sel),
        .tick (tick)
    );

    assign underflow = tick && !wr_count && (count_q == '0);
    assign flag_clr  = wr_ctrl && wstrb[1] && !wdata[BIT_FLAG];

    always_ff @(posedge clk) begin
        if (rst) begin
            const_q <= '1;
            count_q <= '1;
            ctrl_q  <= '0;
        end else begin
            if (wr_const) const_q <= merge_lanes(const_q, wdata, wstrb);
            if (wr_count)
                count_q <= merge_lanes(count_q, wdata, wstrb);
            else if (tick)
                count_q <= (count_q == '0) ? const_q : count_q - 1'b1;
            if (wr_ctrl && wstrb[0]) begin
                ctrl_q.sel <= wdata[SEL_W-1:0];
                ctrl_q.ie  <= wdata[BIT_IE];
            end
            if (underflow)     ctrl_q.flag <= 1'b1;
            else if (flag_clr) ctrl_q.flag <= 1'b0;
        end
    end

    assign irq = ctrl_q.flag && ctrl_q.ie;

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        underflow |=> (count_q == $past(const_q)) && ctrl_q.flag); // R6
    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_count && count_q != '0) |=> count_q == $past(count_q) - 1'b1); // R5
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_count) |=> $stable(count_q)); // R9
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_count && wstrb == '1) |=> count_q == $past(wdata)); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !flag_clr) |=> ctrl_q.flag); // R7
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int LEGACY = 0,
    parameter int AW     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_wstrb,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NCH-1:0]      irq
);
    localparam int START_OFF = (LEGACY != 0) ? 2 : 4;
    localparam int CH_BASE   = (LEGACY != 0) ? 4 : 8;
    localparam int CH_STRIDE = 12;

    if (NCH < 2 || NCH > 3) begin : g_bad_nch
        $error("tmr_unit: NCH must be 2 or 3"); // R1
    end

    logic [NCH-1:0]    start_q;
    logic              hit_start;
    logic [NCH-1:0]    hit_const, hit_count, hit_ctrl;
    logic [DATA_W-1:0] const_arr [NCH];
    logic [DATA_W-1:0] count_arr [NCH];
    ctrl_t             ctrl_arr  [NCH];
    logic [DATA_W-1:0] rd_mux;

    assign hit_start = (bus_addr == AW'(START_OFF));

    always_ff @(posedge clk) begin
        if (rst)                        start_q <= '0;
        else if (bus_wr && hit_start)   start_q <= bus_wdata[NCH-1:0];
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * n;

        assign hit_const[n] = (bus_addr == AW'(BASE));
        assign hit_count[n] = (bus_addr == AW'(BASE + 4));
        assign hit_ctrl[n]  = (bus_addr == AW'(BASE + 8));

        tmr_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .run      (start_q[n]),
            .wr_const (bus_wr && hit_const[n]),
            .wr_count (bus_wr && hit_count[n]),
            .wr_ctrl  (bus_wr && hit_ctrl[n]),
            .wdata    (bus_wdata),
            .wstrb    (bus_wstrb),
            .const_q  (const_arr[n]),
            .count_q  (count_arr[n]),
            .ctrl_q   (ctrl_arr[n]),
            .irq      (irq[n])
        );

        AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
            (irq[n] && !(bus_wr && hit_ctrl[n])) |=> irq[n]); // R8
    end

    always_comb begin
        rd_mux = '0;
        if (hit_start) rd_mux = DATA_W'(start_q);
        for (int n = 0; n < NCH; n++) begin
            if (hit_const[n]) rd_mux = const_arr[n];
            if (hit_count[n]) rd_mux = count_arr[n];
            if (hit_ctrl[n])  rd_mux = ctrl_word(ctrl_arr[n]);
        end
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit_start) |=> start_q == $past(bus_wdata[NCH-1:0])); // R2
endmodule

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_unit #(.NCH(3), .LEGACY(0), .AW(8)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wstrb(bus_wstrb), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference model
    bit [31:0] m_const [3];
    bit [31:0] m_cnt   [3];
    bit        m_flag  [3];
    bit        m_ie    [3];
    int        m_sel   [3];
    int        m_ps    [3];
    int        m_start;

    function automatic bit [31:0] mrg(bit [31:0] o, bit [31:0] d, bit [3:0] s);
        for (int k = 0; k < 4; k++) if (s[k]) o[8*k +: 8] = d[8*k +: 8];
        return o;
    endfunction

    function automatic bit [31:0] model_read(int a);
        bit [31:0] r;
        r = 0;
        if (a == 4) r = 32'(m_start);
        for (int n = 0; n < 3; n++) begin
            if (a == 8 + 12*n)  r = m_const[n];
            if (a == 12 + 12*n) r = m_cnt[n];
            if (a == 16 + 12*n) r = {23'd0, m_flag[n], 2'd0, m_ie[n], 2'd0, 3'(m_sel[n])};
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_start = 0;
            for (int n = 0; n < 3; n++) begin
                m_const[n] = '1; m_cnt[n] = '1; m_flag[n] = 0;
                m_ie[n] = 0; m_sel[n] = 0; m_ps[n] = 0;
            end
        end else begin
            int a;
            a = int'(bus_addr);
            for (int n = 0; n < 3; n++) begin
                bit run, tk, cw;
                int lim, b;
                run = m_start[n];
                lim = (4 << (2 * m_sel[n])) - 1;
                tk  = run && m_sel[n] <= 4 && m_ps[n] >= lim;
                if (!run || m_sel[n] > 4 || tk) m_ps[n] = 0;
                else                            m_ps[n] = m_ps[n] + 1;
                b  = 8 + 12*n;
                cw = bus_wr && a == b + 4;
                if (bus_wr && a == b + 8) begin
                    if (bus_wstrb[1] && !bus_wdata[8]) m_flag[n] = 0;
                    if (bus_wstrb[0]) begin
                        m_sel[n] = int'(bus_wdata[2:0]);
                        m_ie[n]  = bus_wdata[5];
                    end
                end
                if (cw) m_cnt[n] = mrg(m_cnt[n], bus_wdata, bus_wstrb);
                else if (tk) begin
                    if (m_cnt[n] == 0) begin
                        m_cnt[n] = m_const[n];
                        m_flag[n] = 1;
                    end else m_cnt[n] = m_cnt[n] - 1;
                end
                if (bus_wr && a == b) m_const[n] = mrg(m_const[n], bus_wdata, bus_wstrb);
            end
            if (bus_wr && a == 4) m_start = int'(bus_wdata[2:0]);
        end
    end

    task automatic chk(bit [31:0] act, bit [31:0] exp, string req);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // interrupt lines compared every cycle (R8)
    always @(negedge clk) begin
        if (!rst) begin
            chk(32'(irq), {29'd0, m_flag[2] & m_ie[2], m_flag[1] & m_ie[1], m_flag[0] & m_ie[0]}, "R8 irq");
        end
    end

    task automatic wr(int a, bit [31:0] d, bit [3:0] s = 4'hF);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = d; bus_wstrb = s; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, string req);
        @(negedge clk);
        bus_addr = 8'(a); bus_rd = 1'b1;
        #1;
        chk(bus_rdata, model_read(a), req);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R12 reset values
        rd(4, "R12 start");
        rd(8, "R12 const");
        rd(12, "R12 counter");
        rd(16, "R12 control");
        // R11 unmapped, R1 absent channel
        rd(0, "R11 unmapped");
        rd(44, "R1 absent channel");
        // R5 R6 channel 0 counting and reload
        wr(8, 32'd5);
        wr(12, 32'd2);
        wr(16, 32'h20);
        wr(4, 32'h1);
        idle(6);
        rd(12, "R5 counting");
        idle(40);
        rd(12, "R6 reload");
        rd(16, "R6 flag");
        // R7 writing one to flag does nothing, zero clears
        wr(16, 32'h120);
        rd(16, "R7 write one");
        wr(16, 32'h020);
        rd(16, "R7 clear");
        // R7 clear versus underflow on channel 1
        wr(20, 32'd0);
        wr(24, 32'd0);
        wr(28, 32'h20);
        wr(4, 32'h3);
        for (int i = 0; i < 8; i++) begin
            wr(28, 32'h20);
            if (i == 3) idle(1);
            rd(28, "R7 clash");
        end
        // R10 counter write versus tick
        for (int i = 0; i < 8; i++) begin
            wr(24, 32'h10 + 32'(i));
            if (i == 3) idle(1);
            rd(24, "R10 counter write");
        end
        // R4 codes above four give no ticks
        wr(32, 32'd3);
        wr(36, 32'd3);
        wr(40, 32'h25);
        wr(4, 32'h7);
        idle(60);
        rd(36, "R4 no tick code");
        // R4 divide by 16
        wr(12, 32'd20);
        wr(16, 32'h21);
        idle(50);
        rd(12, "R4 divide 16");
        // R9 stop holds counter, restart from fresh prescaler
        wr(4, 32'h6);
        rd(12, "R9 stopped");
        idle(40);
        rd(12, "R9 held");
        wr(4, 32'h7);
        idle(15);
        rd(12, "R9 restart");
        idle(3);
        rd(12, "R9 first tick");
        // R3 byte lanes
        wr(32, 32'hAABBCCDD, 4'b0010);
        rd(32, "R3 lane write");
        wr(36, 32'h11223344, 4'b1001);
        rd(36, "R3 lane write counter");
        // R2 start bits above NCH read zero
        wr(4, 32'hFF);
        rd(4, "R2 start mask");
        wr(4, 32'h5);
        rd(4, "R2 start value");
        // R11 reserved control bits
        wr(40, 32'hFFFF_FEFF);
        rd(40, "R11 reserved bits");
        idle(1);
        nchk++;
        if (bus_rdata !== 32'd0) begin
            nerr++;
            $display("FAIL R11 idle rdata: actual=%h expected=%h", bus_rdata, 32'd0);
        end
        idle(30);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule